// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a larger internal register file through a window of three directly addressed words. The window holds a data word, a control word that carries an internal register address and a write-enable flag, and a status word with a ready flag. For a write, the host loads the data word first and then writes the control word with write-enable set. For a read, it writes the control word with write-enable clear, polls the status word until ready is back, and then takes the result from the data word.

The bridge runs one internal access at a time. Each access is held for a latency that depends on the region its address falls in. A small core register region answers quickly. A management region, which stands in for a slow serial management bus, takes many more cycles. Any address outside both regions behaves like a core access: reads return zero and writes are dropped. A command issued while the bridge is busy is discarded, and a sticky overrun flag records it.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the status word reads 1 (ready set, overrun clear), and the data word and the control word both read 0.
- R2: A write performed as a data-word write (window select 0) followed by a control-word write (select 1) with bit 15 set and the register address in bits 9:0 stores the data value in that internal register.
- R3: A control-word write with bit 15 clear starts a read. Once ready is back, the data word holds the addressed register's value.
- R4: The status word is at select 2, with ready in bit 0 and overrun in bit 1. Ready drops in the cycle after an accepted command and stays low for exactly CORE_LAT cycles (default 2) for addresses 0 to CORE_COUNT-1 (default 0..31).
- R5: Addresses MGMT_BASE to MGMT_BASE+MGMT_COUNT-1 (default 0x200..0x21F) form the management region. Accesses there keep ready low for exactly MGMT_LAT cycles (default 64) and keep their own storage.
- R6: While ready is low, a control-word write is ignored: it changes neither the control word, the access in flight, its timing nor any register. It also sets the overrun flag. A data-word write made while ready is low is ignored as well.
- R7: Overrun stays set until the host writes the status word with bit 1 set, which clears it.
- R8: Addresses in neither region take CORE_LAT cycles, read back as 0, and writes to them are discarded.
- R9: The control word reads back the last accepted address in bits 9:0 and its write-enable in bit 15, with every other bit 0. Window select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the selected window word |
| host_sel | input | 2 | Window word select: 0 data, 1 control, 2 status, 3 reserved |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected window word (combinational) |

## Verification
The block is exercised with writes and reads to the core region, to both ends of the management region and to an unmapped address. Measuring the low time of ready for each region separates the two latency settings and the fallback for unmapped addresses. An overlapping control write issued during a long management read, together with a data write issued during a long write, shows that commands arriving while busy are dropped without shortening or retargeting the access in flight. Reading registers back after writes to different regions shows that the two storage banks are kept apart.

// File: rtl/ibr_pkg.sv
// Shared encodings for the indirect register access bridge.
// Assumes a 2-bit window select and a status word with two flag bits.
package ibr_pkg;
    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_OVR_BIT = 1;

    typedef enum logic [1:0] {
        WIN_DATA = 2'd0,
        WIN_CTRL = 2'd1,
        WIN_STAT = 2'd2,
        WIN_RSVD = 2'd3
    } win_sel_e;

    typedef enum logic [1:0] {
        RGN_CORE = 2'd0,
        RGN_MGMT = 2'd1,
        RGN_NONE = 2'd2
    } region_e;
endpackage

// File: rtl/ibr_region_decode.sv
// Classifies an internal register address into core, management or unmapped,
// and returns the index inside the matching bank.
// Assumes the regions do not overlap and fit inside the address space.
module ibr_region_decode
    import ibr_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int CORE_COUNT = 32,
    parameter int MGMT_BASE  = 512,
    parameter int MGMT_COUNT = 32,
    parameter int OFF_W      = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [OFF_W-1:0]  offset
);
    logic [31:0] addr32;
    assign addr32 = 32'(addr);

    // Pick the region and the bank-relative index.
    always_comb begin
        if (addr32 < 32'(CORE_COUNT)) begin
            region = RGN_CORE;
            offset = OFF_W'(addr32);
        end else if (addr32 >= 32'(MGMT_BASE) &&
                     addr32 < 32'(MGMT_BASE + MGMT_COUNT)) begin
            region = RGN_MGMT;
            offset = OFF_W'(addr32 - 32'(MGMT_BASE));
        end else begin
            region = RGN_NONE;
            offset = '0;
        end
    end
endmodule

// File: rtl/ibr_window.sv
// Host-facing window: data word, control word and status word.
// Accepts a command only while ready is high; a control write while busy is
// dropped and sets the sticky overrun flag. Read completions load the data word.
module ibr_window
    import ibr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int WE_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ready,
    input  logic              cmp_load,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              cmd_issue,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);
    logic              ctrl_write;
    logic              data_write;
    logic              ovr_clear;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic              ovr_q;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] stat_view;

    assign ctrl_write = host_wr && (host_sel == WIN_CTRL);
    assign data_write = host_wr && (host_sel == WIN_DATA) && ready;
    assign ovr_clear  = host_wr && (host_sel == WIN_STAT) && host_wdata[STAT_OVR_BIT];
    assign cmd_issue  = ctrl_write && ready;
    assign cmd_we     = host_wdata[WE_BIT];
    assign cmd_addr   = host_wdata[ADDR_W-1:0];
    assign cmd_wdata  = data_q;

    // Data word: completion load has priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (cmp_load)
            data_q <= cmp_data;
        else if (data_write)
            data_q <= host_wdata;
    end

    // Control word: updated only by an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (cmd_issue) begin
            addr_q <= cmd_addr;
            we_q   <= cmd_we;
        end
    end

    // Sticky overrun: set on a dropped command, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (ctrl_write && !ready)
            ovr_q <= 1'b1;
        else if (ovr_clear)
            ovr_q <= 1'b0;
    end

    // Build the readable views of control and status.
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[ADDR_W-1:0]    = addr_q;
        ctrl_view[WE_BIT]        = we_q;
        stat_view                = '0;
        stat_view[STAT_RDY_BIT]  = ready;
        stat_view[STAT_OVR_BIT]  = ovr_q;
    end

    // Window read multiplexer.
    always_comb begin
        case (host_sel)
            WIN_DATA: host_rdata = data_q;
            WIN_CTRL: host_rdata = ctrl_view;
            WIN_STAT: host_rdata = stat_view;
            default:  host_rdata = '0;
        endcase
    end

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !ready) |=> ovr_q);
    // R6
    busy_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !ready) |=> ($stable(addr_q) && $stable(we_q)));
    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clear) |=> ovr_q);
endmodule

// File: rtl/ibr_sequencer.sv
// Holds one internal access in flight and stretches it by a per-region latency.
// Assumes CORE_LAT and MGMT_LAT are at least 1; ready is low for exactly that many cycles.
module ibr_sequencer
    import ibr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 5,
    parameter int CORE_LAT = 2,
    parameter int MGMT_LAT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_issue,
    input  logic              cmd_we,
    input  region_e           cmd_region,
    input  logic [OFF_W-1:0]  cmd_offset,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              ready,
    output logic              acc_go,
    output logic              acc_we,
    output region_e           acc_region,
    output logic [OFF_W-1:0]  acc_offset,
    output logic [DATA_W-1:0] acc_wdata
);
    localparam int MAX_LAT = (MGMT_LAT > CORE_LAT) ? MGMT_LAT : CORE_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Choose the hold time from the target region.
    always_comb begin
        case (cmd_region)
            RGN_MGMT: load_val = CNT_W'(MGMT_LAT - 1);
            default:  load_val = CNT_W'(CORE_LAT - 1);
        endcase
    end

    // Busy flag and countdown of the access in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cmd_issue) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Capture the command fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_we     <= 1'b0;
            acc_region <= RGN_NONE;
            acc_offset <= '0;
            acc_wdata  <= '0;
        end else if (cmd_issue) begin
            acc_we     <= cmd_we;
            acc_region <= cmd_region;
            acc_offset <= cmd_offset;
            acc_wdata  <= cmd_wdata;
        end
    end

    assign ready  = !busy_q;
    assign acc_go = busy_q && (cnt_q == '0);

    // R4
    issue_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> !ready);
    // R6
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> ready);
    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> (ready && !acc_go));
endmodule

// File: rtl/ibr_regfile.sv
// Internal register storage: one bank per mapped region, built by a generate loop.
// Assumes each bank count is a power of two no larger than 2**OFF_W.
module ibr_regfile
    import ibr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 5,
    parameter int CORE_COUNT = 32,
    parameter int MGMT_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_we,
    input  region_e           acc_region,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NUM_BANKS = 2;

    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int      CNT = (g == 0) ? CORE_COUNT : MGMT_COUNT;
        localparam int      IW  = $clog2(CNT);
        localparam region_e MY  = (g == 0) ? RGN_CORE : RGN_MGMT;

        logic [DATA_W-1:0] mem [CNT];
        logic              we_b;
        logic [IW-1:0]     idx;

        assign we_b = acc_go && acc_we && (acc_region == MY);
        assign idx  = acc_offset[IW-1:0];

        // Bank storage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < CNT; i++)
                    mem[i] <= '0;
            end else if (we_b) begin
                mem[idx] <= acc_wdata;
            end
        end

        assign bank_rd[g] = mem[idx];
    end

    // Route the addressed bank to the read result; unmapped reads give zero.
    always_comb begin
        case (acc_region)
            RGN_CORE: rd_data = bank_rd[0];
            RGN_MGMT: rd_data = bank_rd[1];
            default:  rd_data = '0;
        endcase
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && acc_region == RGN_NONE) |-> (rd_data == '0));
endmodule

// File: rtl/ibr_bridge.sv
// Top of the indirect register access bridge: window, address decode,
// latency sequencer and banked register file.
// Assumes the host polls ready before issuing a command.
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 10,
    parameter int WE_BIT     = 15,
    parameter int CORE_COUNT = 32,
    parameter int MGMT_BASE  = 512,
    parameter int MGMT_COUNT = 32,
    parameter int CORE_LAT   = 2,
    parameter int MGMT_LAT   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int BIG_COUNT = (MGMT_COUNT > CORE_COUNT) ? MGMT_COUNT : CORE_COUNT;
    localparam int OFF_W     = $clog2(BIG_COUNT);

    logic              ready;
    logic              cmd_issue;
    logic              cmd_we;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    region_e           cmd_region;
    logic [OFF_W-1:0]  cmd_offset;
    logic              acc_go;
    logic              acc_we;
    region_e           acc_region;
    logic [OFF_W-1:0]  acc_offset;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] rd_data;
    logic              cmp_load;

    assign cmp_load = acc_go && !acc_we;

    ibr_window #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WE_BIT(WE_BIT)) u_window (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ready(ready),
        .cmp_load(cmp_load), .cmp_data(rd_data), .cmd_issue(cmd_issue),
        .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    ibr_region_decode #(.ADDR_W(ADDR_W), .CORE_COUNT(CORE_COUNT),
                        .MGMT_BASE(MGMT_BASE), .MGMT_COUNT(MGMT_COUNT),
                        .OFF_W(OFF_W)) u_decode (
        .addr(cmd_addr), .region(cmd_region), .offset(cmd_offset)
    );

    ibr_sequencer #(.DATA_W(DATA_W), .OFF_W(OFF_W), .CORE_LAT(CORE_LAT),
                    .MGMT_LAT(MGMT_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_we(cmd_we),
        .cmd_region(cmd_region), .cmd_offset(cmd_offset), .cmd_wdata(cmd_wdata),
        .ready(ready), .acc_go(acc_go), .acc_we(acc_we), .acc_region(acc_region),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata)
    );

    ibr_regfile #(.DATA_W(DATA_W), .OFF_W(OFF_W), .CORE_COUNT(CORE_COUNT),
                  .MGMT_COUNT(MGMT_COUNT)) u_rf (
        .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_we(acc_we),
        .acc_region(acc_region), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .rd_data(rd_data)
    );
endmodule

// File: tb/ibr_bridge_tb.sv
module ibr_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CORE_LAT   = 2;
    localparam int MGMT_LAT   = 64;
    localparam logic [31:0] WE = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        mon_req = 1'b0;

    ibr_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops the expected word and compares it with the window output.
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (host_rdata !== e) begin
                errors++;
                $display("FAIL %s: actual=%08h expected=%08h", t, host_rdata, e);
            end
        end
    end

    task automatic check_int(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        host_sel   = sel;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk); #1;
        host_wr    = 1'b0;
    endtask

    // Driver: pushes an expected word and requests one comparison.
    task automatic expect_word(input logic [1:0] sel, input logic [31:0] v, input string t);
        host_sel = sel;
        exp_q.push_back(v);
        tag_q.push_back(t);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    // Counts the negedges with ready low, starting right after a command.
    task automatic measure_busy(output int n);
        host_sel = 2'd2;
        n = 0;
        forever begin
            @(negedge clk);
            if (host_rdata[0]) break;
            n++;
        end
        @(posedge clk); #1;
    endtask

    task automatic wait_ready();
        int n;
        measure_busy(n);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_word(2'd2, 32'h1, "R1 status after reset");
        expect_word(2'd0, 32'h0, "R1 data after reset");
        expect_word(2'd1, 32'h0, "R1 control after reset");

        // R2/R4 core write with latency
        bus_write(2'd0, 32'hA5A5_0001);
        bus_write(2'd1, WE | 32'd5);
        measure_busy(n);
        check_int("R4 core write busy cycles", n, CORE_LAT);
        expect_word(2'd1, 32'h0000_8005, "R9 control readback write");
        expect_word(2'd3, 32'h0, "R9 reserved select reads zero");

        // Top core register
        bus_write(2'd0, 32'h1234_5678);
        bus_write(2'd1, WE | 32'd31);
        wait_ready();

        // R3 read back
        bus_write(2'd1, 32'd5);
        measure_busy(n);
        check_int("R4 core read busy cycles", n, CORE_LAT);
        expect_word(2'd0, 32'hA5A5_0001, "R3 read core 5");
        expect_word(2'd1, 32'h0000_0005, "R9 control readback read");
        bus_write(2'd1, 32'd31);
        wait_ready();
        expect_word(2'd0, 32'h1234_5678, "R2 read core 31");
        bus_write(2'd1, 32'd0);
        wait_ready();
        expect_word(2'd0, 32'h0, "R3 read unwritten core 0");

        // R5 management region, both ends
        bus_write(2'd0, 32'hCAFE_0203);
        bus_write(2'd1, WE | 32'h203);
        measure_busy(n);
        check_int("R5 mgmt write busy cycles", n, MGMT_LAT);
        bus_write(2'd0, 32'hBEEF_021F);
        bus_write(2'd1, WE | 32'h21F);
        wait_ready();
        bus_write(2'd1, 32'h203);
        measure_busy(n);
        check_int("R5 mgmt read busy cycles", n, MGMT_LAT);
        expect_word(2'd0, 32'hCAFE_0203, "R5 read mgmt 0x203");
        bus_write(2'd1, 32'd3);
        wait_ready();
        expect_word(2'd0, 32'h0, "R5 core 3 separate from mgmt 0x203");
        bus_write(2'd1, 32'h21F);
        wait_ready();
        expect_word(2'd0, 32'hBEEF_021F, "R5 read mgmt 0x21F");

        // R6 overlapping control write during a long read
        bus_write(2'd1, 32'h203);
        bus_write(2'd1, WE | 32'd5);
        expect_word(2'd2, 32'h2, "R6 busy and overrun set");
        measure_busy(n);
        check_int("R6 in-flight access keeps its latency", n, MGMT_LAT - 2);
        expect_word(2'd0, 32'hCAFE_0203, "R6 data from original read");
        expect_word(2'd1, 32'h0000_0203, "R6 control unchanged");
        expect_word(2'd2, 32'h3, "R7 overrun sticky after ready");
        bus_write(2'd1, 32'd5);
        wait_ready();
        expect_word(2'd0, 32'hA5A5_0001, "R6 dropped write left core 5");

        // R6 data write while busy is ignored
        bus_write(2'd0, 32'h0000_7777);
        bus_write(2'd1, WE | 32'h210);
        bus_write(2'd0, 32'h0000_9999);
        wait_ready();
        expect_word(2'd0, 32'h0000_7777, "R6 data write while busy ignored");

        // R7 clear overrun
        bus_write(2'd2, 32'h2);
        expect_word(2'd2, 32'h1, "R7 overrun cleared");

        // R8 unmapped address
        bus_write(2'd0, 32'h5555_AAAA);
        bus_write(2'd1, WE | 32'h100);
        measure_busy(n);
        check_int("R8 unmapped write busy cycles", n, CORE_LAT);
        bus_write(2'd1, 32'h100);
        measure_busy(n);
        check_int("R8 unmapped read busy cycles", n, CORE_LAT);
        expect_word(2'd0, 32'h0, "R8 unmapped read zero");
        bus_write(2'd1, 32'h1FF);
        wait_ready();
        expect_word(2'd0, 32'h0, "R8 address below mgmt base reads zero");
        bus_write(2'd1, 32'h210);
        wait_ready();
        expect_word(2'd0, 32'h0000_7777, "R5 mgmt 0x210 written value");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule